// File: doc/BRIEF.md
# Charge-Scaling DAC Phase Controller

This block sequences the switches around a binary-weighted capacitor DAC whose output stage is an integrating amplifier with offset storage. Each conversion request starts a fixed sequence. First comes a reset phase. In it the capacitor array is cut off from the amplifier and the amplifier is placed in unity gain. The integrating capacitor's bottom plate is grounded so that the amplifier offset is stored on it, and the array plates are all grounded.

After one clock in which every switch rests in a safe state, a charge phase follows. In the charge phase the array is reconnected, and each weighted capacitor's bottom plate goes to the reference or to ground according to the code that was captured when the request was accepted.

The array holds `NBITS` capacitors of weight 2^i units plus one terminating unit, so the full array is 2^NBITS units. The ideal output is therefore the code value divided by 2^NBITS, times the reference. Once the charge phase has lasted its programmed length, a valid flag rises. The flag and the charge configuration are held until the next request. The analog array and the amplifier sit outside this block.

Top module: `cdac_phase_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the idle state that follows reset, every switch output is low, every plate select is 0 (ground) and `out_valid` is 0.
- R2: A request (`req` high at a rising edge while idle or done) starts the reset phase on the next cycle. The reset phase lasts `RST_CYCLES` cycles with `arr_reset`=1, `sw_unity`=1, `sw_cint_gnd`=1, `sw_array_conn`=0 and all plate selects 0.
- R3: Exactly one cycle separates the reset and charge phases. In that cycle all four switch outputs are 0 and all plate selects are 0.
- R4: The charge phase lasts `CHG_CYCLES` cycles with `sw_array_conn`=1, `sw_unity`=0, `sw_cint_gnd`=0 and `arr_reset`=0. `plate_sel[i]` equals bit i of the captured code, where 1 selects the reference and 0 selects ground. The weighted sum of the selects over 2^NBITS equals code/2^NBITS, so for NBITS=4 the code 1011b gives 11/16.
- R5: The code is captured at the edge that accepts the request. Later changes on `code` have no effect on the plate selects until the next accepted request.
- R6: `out_valid` rises on the cycle after the last charge cycle. It stays high with the charge configuration held until the next accepted request, after which it is 0 from the first reset cycle.
- R7: A request that arrives during the reset, gap or charge phase is ignored: the phase sequence and its timing continue unchanged.
- R8: Whenever `sw_array_conn` is 0, every plate select is 0. `sw_array_conn` is never high together with `sw_unity` or `sw_cint_gnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Conversion request, sampled at rising edges |
| code | input | NBITS | Digital word to convert |
| plate_sel | output | NBITS | Bottom-plate select per weighted capacitor, 1 = reference |
| arr_reset | output | 1 | Array reset line, high during the reset phase |
| sw_unity | output | 1 | Closes the amplifier unity-gain feedback switch |
| sw_cint_gnd | output | 1 | Grounds the integrating capacitor's bottom plate |
| sw_array_conn | output | 1 | Connects the capacitor array to the amplifier input |
| out_valid | output | 1 | Output settled after a full charge phase |

## Verification
Every one of the 16 codes of a 4-bit array is converted in turn. The plate selects seen in the charge phase are folded into a weighted fraction and compared with code/16. This separates bit-order faults from stuck or swapped plates, and the all-zero and all-one codes mark the two ends of the range. Directly after each request the `code` input is changed to its complement. A design that fails to capture the code then produces a visibly different fraction. On alternate codes an extra request is injected during reset and during charge. Each cycle of every conversion is compared with the expected phase pattern, which exposes wrong phase lengths, a missing gap and valid-flag timing errors.

// File: rtl/cdac_pkg.sv
package cdac_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_RESET  = 3'd1,
      PH_GAP    = 3'd2,
      PH_CHARGE = 3'd3,
      PH_DONE   = 3'd4
   } cdac_phase_e;

   typedef struct packed {
      logic arr_rst;
      logic unity;
      logic cint_gnd;
      logic arr_conn;
   } cdac_sw_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // total unit capacitors in a binary array of n bits plus terminator
   function automatic longint unsigned array_units(input int unsigned n);
      longint unsigned s;
      s = 1;
      for (int unsigned i = 0; i < n; i++) s += (longint'(1) << i);
      return s;
   endfunction

endpackage

// File: rtl/cdac_phase_seq.sv
module cdac_phase_seq
   import cdac_pkg::*;
#(
   parameter int unsigned RST_CYCLES = 3,
   parameter int unsigned CHG_CYCLES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   output cdac_phase_e phase,
   output logic        capture
);
   localparam int unsigned MAX_LEN = max_u(RST_CYCLES, CHG_CYCLES);
   localparam int unsigned CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
   localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYCLES - 1);
   localparam logic [CNT_W-1:0] CHG_LAST = CNT_W'(CHG_CYCLES - 1);

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("cdac_phase_seq: RST_CYCLES must be at least 1");
   end
   if (CHG_CYCLES < 1) begin : g_bad_chg
      $error("cdac_phase_seq: CHG_CYCLES must be at least 1");
   end

   cdac_phase_e      ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             accept;

   assign accept  = req && (ph_q == PH_IDLE || ph_q == PH_DONE);
   assign capture = accept;
   assign phase   = ph_q;

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      unique case (ph_q)
         PH_IDLE, PH_DONE: begin
            if (accept) begin
               ph_d  = PH_RESET;
               cnt_d = '0;
            end
         end
         PH_RESET: begin
            if (cnt_q == RST_LAST) begin
               ph_d  = PH_GAP;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_GAP: begin
            ph_d  = PH_CHARGE;
            cnt_d = '0;
         end
         PH_CHARGE: begin
            if (cnt_q == CHG_LAST) begin
               ph_d  = PH_DONE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            ph_d  = PH_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
      end
   end

   // R3: the gap always lasts one cycle and leads into charge
   assert_gap_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_GAP) |=> (ph_q == PH_CHARGE));

   // R3: reset never leads straight into charge
   assert_reset_to_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_RESET) |=> (ph_q == PH_RESET || ph_q == PH_GAP));

   // R7: a busy sequence never restarts on a request
   assert_busy_ignores_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CHARGE) |=> (ph_q == PH_CHARGE || ph_q == PH_DONE));

   // R2: counter stays inside the active phase's window
   assert_cnt_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q == PH_RESET) |-> (cnt_q <= RST_LAST)) and
      ((ph_q == PH_CHARGE) |-> (cnt_q <= CHG_LAST)));

endmodule

// File: rtl/cdac_code_latch.sv
module cdac_code_latch #(
   parameter int unsigned NBITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [NBITS-1:0] code,
   input  logic             drive_en,
   output logic [NBITS-1:0] plate_sel
);
   logic [NBITS-1:0] held_q;

   for (genvar i = 0; i < NBITS; i++) begin : g_plate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       held_q[i] <= 1'b0;
         else if (capture) held_q[i] <= code[i];
      end
      assign plate_sel[i] = held_q[i] & drive_en;
   end

   // R5: captured word changes only on an accepted request
   assert_hold_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> $stable(held_q));

endmodule

// File: rtl/cdac_sw_decode.sv
module cdac_sw_decode
   import cdac_pkg::*;
(
   input  cdac_phase_e phase,
   output cdac_sw_t    sw,
   output logic        drive_en,
   output logic        valid
);
   always_comb begin
      sw       = '0;
      drive_en = 1'b0;
      valid    = 1'b0;
      unique case (phase)
         PH_RESET: begin
            sw.arr_rst  = 1'b1;
            sw.unity    = 1'b1;
            sw.cint_gnd = 1'b1;
         end
         PH_CHARGE: begin
            sw.arr_conn = 1'b1;
            drive_en    = 1'b1;
         end
         PH_DONE: begin
            sw.arr_conn = 1'b1;
            drive_en    = 1'b1;
            valid       = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cdac_phase_ctrl.sv
module cdac_phase_ctrl
   import cdac_pkg::*;
#(
   parameter int unsigned NBITS      = 4,
   parameter int unsigned RST_CYCLES = 3,
   parameter int unsigned CHG_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [NBITS-1:0] code,
   output logic [NBITS-1:0] plate_sel,
   output logic             arr_reset,
   output logic             sw_unity,
   output logic             sw_cint_gnd,
   output logic             sw_array_conn,
   output logic             out_valid
);
   localparam longint unsigned UNIT_TOTAL = longint'(1) << NBITS;

   if (NBITS < 1 || NBITS > 24) begin : g_bad_bits
      $error("cdac_phase_ctrl: NBITS out of range 1..24");
   end
   if (array_units(NBITS) != UNIT_TOTAL) begin : g_bad_units
      $error("cdac_phase_ctrl: array units do not sum to 2^NBITS");
   end

   cdac_phase_e ph;
   logic        cap;
   cdac_sw_t    sw;
   logic        drv;

   cdac_phase_seq #(
      .RST_CYCLES (RST_CYCLES),
      .CHG_CYCLES (CHG_CYCLES)
   ) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .phase   (ph),
      .capture (cap)
   );

   cdac_sw_decode dec_i (
      .phase    (ph),
      .sw       (sw),
      .drive_en (drv),
      .valid    (out_valid)
   );

   cdac_code_latch #(.NBITS(NBITS)) lat_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (cap),
      .code      (code),
      .drive_en  (drv),
      .plate_sel (plate_sel)
   );

   assign arr_reset     = sw.arr_rst;
   assign sw_unity      = sw.unity;
   assign sw_cint_gnd   = sw.cint_gnd;
   assign sw_array_conn = sw.arr_conn;

   // R8: plates grounded whenever the array is isolated
   assert_plates_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_array_conn |-> (plate_sel == '0));

   // R8: array connection excludes the offset-storage switches
   assert_switch_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_array_conn |-> !(sw_unity || sw_cint_gnd));

   // R3: break before make between unity gain and array connection
   assert_break_make_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_unity) |-> !sw_array_conn);

   // R6: valid only follows a connected array and holds the plates
   assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> ($stable(plate_sel) && sw_array_conn));

   // R6: valid rises only out of the charge phase
   assert_valid_after_charge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(sw_array_conn));

endmodule

// File: tb/cdac_phase_ctrl_tb.sv
module cdac_phase_ctrl_tb_top;
   localparam int NB = 4;
   localparam int RC = 3;
   localparam int CC = 4;
   localparam time CLK_PERIOD = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [NB-1:0] code = '0;
   logic [NB-1:0] plate_sel;
   logic arr_reset, sw_unity, sw_cint_gnd, sw_array_conn, out_valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cdac_phase_ctrl #(.NBITS(NB), .RST_CYCLES(RC), .CHG_CYCLES(CC)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .code(code),
      .plate_sel(plate_sel), .arr_reset(arr_reset), .sw_unity(sw_unity),
      .sw_cint_gnd(sw_cint_gnd), .sw_array_conn(sw_array_conn),
      .out_valid(out_valid)
   );

   // packed as {arr_reset, unity, cint_gnd, array_conn, valid, plates}
   function automatic logic [NB+4:0] pack_exp(input int ph, input logic [NB-1:0] c);
      // ph: 0 idle/gap, 1 reset, 2 charge, 3 done
      case (ph)
         1: return {5'b11100, {NB{1'b0}}};
         2: return {5'b00010, c};
         3: return {5'b00011, c};
         default: return {5'b00000, {NB{1'b0}}};
      endcase
   endfunction

   task automatic check_vec(input logic [NB+4:0] exp, input string req_tag);
      logic [NB+4:0] act;
      act = {arr_reset, sw_unity, sw_cint_gnd, sw_array_conn, out_valid, plate_sel};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs actual=%b expected=%b", req_tag, act, exp);
      end
   endtask

   task automatic check_fraction(input logic [NB-1:0] c);
      int num;
      num = 0;
      for (int i = 0; i < NB; i++) if (plate_sel[i]) num += (1 << i);
      n_checks++;
      if (num != int'(c)) begin
         n_fail++;
         $display("FAIL R4: output fraction actual=%0d/%0d expected=%0d/%0d",
                  num, 1 << NB, c, 1 << NB);
      end
   endtask

   function automatic int phase_at(input int n);
      if (n <= RC) return 1;
      if (n == RC + 1) return 0;
      if (n <= RC + CC + 1) return 2;
      return 3;
   endfunction

   function automatic string tag_of(input int ph);
      case (ph)
         1: return "R2";
         2: return "R4";
         3: return "R6";
         default: return "R3";
      endcase
   endfunction

   initial begin
      @(negedge clk);
      check_vec(pack_exp(0, '0), "R1");   // R1 during reset
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_vec(pack_exp(0, '0), "R1");   // R1 idle after reset
      for (int c = 0; c < (1 << NB); c++) begin
         req  = 1'b1;
         code = NB'(c);
         @(negedge clk);
         req  = 1'b0;
         code = ~NB'(c);                  // R5: late change must not matter
         for (int n = 1; n <= RC + CC + 3; n++) begin
            int ph;
            ph = phase_at(n);
            check_vec(pack_exp(ph, NB'(c)), (n > 1 && n <= RC) ? "R5" : tag_of(ph));
            if (ph == 2 || ph == 3) check_fraction(NB'(c));
            // R7: stray requests during reset and charge on odd codes
            if ((c % 2) == 1 && (n == 1 || n == RC + 2)) req = 1'b1;
            else req = 1'b0;
            code = NB'(c + n);            // R5: keep moving the input word
            @(negedge clk);
         end
      end
      req = 1'b0;
      @(negedge clk);
      check_vec(pack_exp(3, NB'((1 << NB) - 1)), "R6");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule